// File: doc/BRIEF.md
# Expansion-Factor Reconstruction Stage

This block sits at the output of an exact, integer-only 8-point DCT datapath. That datapath leaves each transform coefficient as four signed integers. Each integer weights one basis value: 1, z1, z2 and the product z1·z2. The stage folds the four integers into one fixed-point number. It does this without any irrational multiplier.

All three irrational basis values are scaled by one shared expansion factor α, chosen so that each product lands very close to an integer. The z-channels are then multiplied by small integer weights through shared partial sums. The 1-channel is multiplied by α itself, written as a short signed-digit shift-add network. The result is the true coefficient times α. Removing α is left to a later quantizer.

The parameter `VARIANT` selects one of two versions:
- A cheap version with α ≈ 4.5958.
- A precise version with α ≈ 167.2309.

One copy of the stage is placed per coefficient. A coefficient that does not use a channel has that channel tied to zero.

Top module: `efx_recon`

## Requirements
- R1: While `rst_n` is low and on the first sample after it is released, `out_valid` is 0 and `coef_out` is 0.
- R2: `out_valid` repeats `in_valid` exactly two rising clock edges later. This holds for isolated pulses, back-to-back inputs and gaps.
- R3: With `VARIANT`=0, the integer part of the result is 12·xb + 5·xc + 13·xd.
- R4: With `VARIANT`=0, xa is weighted by exactly 2353/512. That is 2^2+2^-1+2^-4+2^-5+2^-9, about 4.5957.
- R5: With `VARIANT`=1, the integer part of the result is 437·xb + 181·xc + 473·xd.
- R6: With `VARIANT`=1, xa is weighted by exactly 85622/512. That is 2^7+2^5+2^3−2^0+2^-2−2^-6−2^-8, about 167.2305.
- R7: The output format is as follows, and the result is exact with no wrap for every combination of extreme signed inputs:
  - `coef_out` is two's complement.
  - Its least significant bit weighs 2^-9.
  - Its width is W + clog2(G) + 9, with G = 35 for variant 0 and G = 1259 for variant 1. For W = 12 this gives 27 and 32 bits.
- R8: While a cycle carries no valid result (`out_valid` low), `coef_out` keeps the value of the most recent valid result. Inputs presented with `in_valid` low never reach the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Qualifies the four channel inputs this cycle |
| xa | input | W | Signed integer weighting basis value 1 |
| xb | input | W | Signed integer weighting basis value z1 |
| xc | input | W | Signed integer weighting basis value z2 |
| xd | input | W | Signed integer weighting basis value z1·z2 |
| out_valid | output | 1 | Marks a fresh reconstructed coefficient |
| coef_out | output | OUT_W | α-scaled coefficient, 9 fractional bits |

## Verification
The bench drives one input channel at a time as single-channel impulses. A wrong weight, or a swapped channel in the shared partial sums, then shows up directly as a wrong multiple.

It applies all-maximum, all-minimum and mixed-sign extremes to both variants. An output width that is one bit short, or a missing sign extension, would wrap those results to the opposite sign.

It inserts gaps that carry garbage data on the channel inputs. A stage register that loads without qualification would leak that garbage to `coef_out`. A miscounted pipeline would raise `out_valid` one cycle early or late.

// File: rtl/efx_recon_pkg.sv
package efx_recon_pkg;

   // fractional bits carried by the fixed-point result
   localparam int FRAC_BITS = 9;

   typedef enum int {
      EFX_LOW_AREA = 0,
      EFX_HIGH_ACC = 1
   } efx_variant_e;

   // upper bound on the total gain from all four channels
   // (ceiling of alpha plus the three integer weights)
   function automatic int gain_bound(input int variant);
      return (variant == EFX_LOW_AREA) ? 35 : 1259;
   endfunction

   function automatic int gain_bits(input int variant);
      return $clog2(gain_bound(variant));
   endfunction

endpackage

// File: rtl/efx_alpha_term.sv
// Multiplies the basis-1 channel by the expansion factor alpha.
// The result sits on the 2^-FRAC grid.
module efx_alpha_term #(
   parameter int W       = 12,
   parameter int VARIANT = 0,
   parameter int FRAC    = 9,
   parameter int OUT_W   = 27
) (
   input  logic signed [W-1:0]     xa,
   output logic signed [OUT_W-1:0] a_term
);

   localparam int EXT = OUT_W - W;

   logic signed [OUT_W-1:0] x;
   assign x = {{EXT{xa[W-1]}}, xa};

   // every signed digit 2^k becomes a left shift by k+FRAC
   generate
      if (VARIANT == 0) begin : g_low
         // 2^2 + 2^-1 + 2^-4 + 2^-5 + 2^-9
         always_comb
            a_term = (x <<< (FRAC + 2)) + (x <<< (FRAC - 1))
                   + (x <<< (FRAC - 4)) + (x <<< (FRAC - 5))
                   + (x <<< (FRAC - 9));
      end else begin : g_high
         // 2^7 + 2^5 + 2^3 - 2^0 + 2^-2 - 2^-6 - 2^-8
         always_comb
            a_term = (x <<< (FRAC + 7)) + (x <<< (FRAC + 5))
                   + (x <<< (FRAC + 3)) - (x <<< FRAC)
                   + (x <<< (FRAC - 2)) - (x <<< (FRAC - 6))
                   - (x <<< (FRAC - 8));
      end
   endgenerate

endmodule

// File: rtl/efx_int_term.sv
// Integer-weighted sum of the three irrational-basis channels,
// built from shared partial sums.
module efx_int_term #(
   parameter int W       = 12,
   parameter int VARIANT = 0,
   parameter int IW      = 18
) (
   input  logic signed [W-1:0]  xb,
   input  logic signed [W-1:0]  xc,
   input  logic signed [W-1:0]  xd,
   output logic signed [IW-1:0] i_term
);

   localparam int EXT = IW - W;

   logic signed [IW-1:0] b, c, d;
   assign b = {{EXT{xb[W-1]}}, xb};
   assign c = {{EXT{xc[W-1]}}, xc};
   assign d = {{EXT{xd[W-1]}}, xd};

   generate
      if (VARIANT == 0) begin : g_low
         // weights 12, 5, 13 from 8(b+d) + 4(b+c+d) + (c+d)
         logic signed [IW-1:0] s_bd, s_bcd, s_cd;
         always_comb begin
            s_bd   = b + d;
            s_bcd  = s_bd + c;
            s_cd   = c + d;
            i_term = (s_bd <<< 3) + (s_bcd <<< 2) + s_cd;
         end
      end else begin : g_high
         // weights 437, 181, 473 from 473(b+c+d) - 36(b+c) - 256c
         // where 473 = 512 - 32 - 8 + 1 and 36 = 32 + 4
         logic signed [IW-1:0] s_bc, s_bcd, p473, p36;
         always_comb begin
            s_bc   = b + c;
            s_bcd  = s_bc + d;
            p473   = (s_bcd <<< 9) - (s_bcd <<< 5) - (s_bcd <<< 3) + s_bcd;
            p36    = (s_bc <<< 5) + (s_bc <<< 2);
            i_term = p473 - p36 - (c <<< 8);
         end
      end
   endgenerate

endmodule

// File: rtl/efx_recon.sv
module efx_recon #(
   parameter  int W       = 12,
   parameter  int VARIANT = 0,
   localparam int OUT_W   = W + efx_recon_pkg::gain_bits(VARIANT)
                              + efx_recon_pkg::FRAC_BITS
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic signed [W-1:0]     xa,
   input  logic signed [W-1:0]     xb,
   input  logic signed [W-1:0]     xc,
   input  logic signed [W-1:0]     xd,
   output logic                    out_valid,
   output logic signed [OUT_W-1:0] coef_out
);

   import efx_recon_pkg::*;

   localparam int FRAC = FRAC_BITS;
   localparam int IW   = OUT_W - FRAC;

   // elaboration-time parameter checks
   generate
      if (W < 2) begin : g_bad_width
         $error("efx_recon: W must be at least 2");
      end
      if (VARIANT != EFX_LOW_AREA && VARIANT != EFX_HIGH_ACC) begin : g_bad_variant
         $error("efx_recon: VARIANT must be 0 or 1");
      end
   endgenerate

   logic signed [OUT_W-1:0] a_term;
   logic signed [IW-1:0]    i_term;

   efx_alpha_term #(.W(W), .VARIANT(VARIANT), .FRAC(FRAC), .OUT_W(OUT_W)) u_alpha (
      .xa     (xa),
      .a_term (a_term)
   );

   efx_int_term #(.W(W), .VARIANT(VARIANT), .IW(IW)) u_int (
      .xb     (xb),
      .xc     (xc),
      .xd     (xd),
      .i_term (i_term)
   );

   // stage 1: register both partial products
   logic                    s1_valid;
   logic signed [OUT_W-1:0] a_q;
   logic signed [IW-1:0]    i_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         a_q      <= '0;
         i_q      <= '0;
      end else begin
         s1_valid <= in_valid;
         if (in_valid) begin
            a_q <= a_term;
            i_q <= i_term;
         end
      end
   end

   // stage 2: align the integer sum to the fractional grid and add
   logic signed [OUT_W-1:0] i_aligned;
   assign i_aligned = {i_q, {FRAC{1'b0}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         coef_out  <= '0;
      end else begin
         out_valid <= s1_valid;
         if (s1_valid)
            coef_out <= a_q + i_aligned;
      end
   end

   // R2: each stage delays the strobe by one edge
   a_r2_stage1_valid: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (s1_valid == $past(in_valid)));

   a_r2_stage2_valid: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == $past(s1_valid));

   // R8: no new result means the output register keeps its value
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(s1_valid)) |-> $stable(coef_out));

   // R4 / R6: alpha is positive, so it preserves the sign of xa
   a_r4_alpha_pos: assert property (@(posedge clk) disable iff (!rst_n)
      (xa > 0) |-> (a_term > 0));

   a_r6_alpha_neg: assert property (@(posedge clk) disable iff (!rst_n)
      (xa < 0) |-> (a_term < 0));

   // R3 / R5: zero z-channels contribute nothing
   a_r3_int_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (xb == 0 && xc == 0 && xd == 0) |-> (i_term == 0));

endmodule

// File: tb/efx_recon_test.sv
module efx_recon_test;

   localparam int W   = 12;
   localparam int OW0 = 27;   // R7: 12 + clog2(35) + 9
   localparam int OW1 = 32;   // R7: 12 + clog2(1259) + 9

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic signed [W-1:0] xa = '0, xb = '0, xc = '0, xd = '0;
   logic                  ov0, ov1;
   logic signed [OW0-1:0] co0;
   logic signed [OW1-1:0] co1;

   always #2 clk = ~clk;   // 250 MHz

   efx_recon #(.W(W), .VARIANT(0)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .xa(xa), .xb(xb), .xc(xc), .xd(xd),
      .out_valid(ov0), .coef_out(co0));

   efx_recon #(.W(W), .VARIANT(1)) uut_hi (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .xa(xa), .xb(xb), .xc(xc), .xd(xd),
      .out_valid(ov1), .coef_out(co1));

   int checks = 0;
   int failures = 0;

   // alpha on the 2^-9 grid, summed from the signed digits
   localparam longint ALPHA0 = 4*512 + 512/2 + 512/16 + 512/32 + 1;
   localparam longint ALPHA1 = 128*512 + 32*512 + 8*512 - 512
                               + 512/4 - 512/64 - 512/256;

   function automatic longint ref_low(longint a, longint b, longint c, longint d);
      return a*ALPHA0 + (12*b + 5*c + 13*d)*512;
   endfunction

   function automatic longint ref_high(longint a, longint b, longint c, longint d);
      return a*ALPHA1 + (437*b + 181*c + 473*d)*512;
   endfunction

   // reference pipeline: p1 = driven one negedge ago, p2 = two ago
   bit     p1_v = 0, p2_v = 0;
   longint p1_a, p1_b, p1_c, p1_d, p2_a, p2_b, p2_c, p2_d;
   string  p1_t = "R2", p2_t = "R2";
   longint last0 = 0, last1 = 0;

   task automatic chk(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic compare();
      string t;
      if (p2_v) begin
         last0 = ref_low(p2_a, p2_b, p2_c, p2_d);
         last1 = ref_high(p2_a, p2_b, p2_c, p2_d);
      end
      t = p2_v ? p2_t : "R8";
      chk("R2 valid low-area", longint'(ov0), longint'(p2_v));
      chk("R2 valid high-acc", longint'(ov1), longint'(p2_v));
      chk({t, " coef low-area"}, longint'(co0), last0);
      chk({t, " coef high-acc"}, longint'(co1), last1);
   endtask

   task automatic step(input bit v, input int a, input int b, input int c,
                       input int d, input string tag);
      @(negedge clk);
      compare();
      p2_v = p1_v; p2_a = p1_a; p2_b = p1_b; p2_c = p1_c; p2_d = p1_d; p2_t = p1_t;
      p1_v = v;    p1_a = a;    p1_b = b;    p1_c = c;    p1_d = d;    p1_t = tag;
      in_valid = v;
      xa = W'(a); xb = W'(b); xc = W'(c); xd = W'(d);
   endtask

   function automatic int rnd();
      return int'($urandom % 4096) - 2048;
   endfunction

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL R2 watchdog actual=timeout expected=completion");
      summary();
      $finish;
   end

   initial begin
      // R1: reset state, sampled while reset is still held
      repeat (3) @(negedge clk);
      chk("R1 reset valid low-area", longint'(ov0), 0);
      chk("R1 reset valid high-acc", longint'(ov1), 0);
      chk("R1 reset coef low-area", longint'(co0), 0);
      chk("R1 reset coef high-acc", longint'(co1), 0);
      rst_n = 1'b1;

      // single-channel impulses
      step(1, 1, 0, 0, 0, "R4/R6 alpha unit");
      step(1, 0, 1, 0, 0, "R3/R5 z1 weight");
      step(1, 0, 0, 1, 0, "R3/R5 z2 weight");
      step(1, 0, 0, 0, 1, "R3/R5 z1z2 weight");
      step(1, -1, 0, 0, 0, "R4/R6 alpha negative");
      step(1, 0, -3, 7, -5, "R3/R5 mixed int");

      // isolated pulse and gaps carrying garbage
      step(0, 999, -999, 555, -555, "R8");
      step(0, 1234, 42, -7, 3, "R8");
      step(1, 17, 0, 0, 0, "R4/R6 after gap");
      step(0, -2048, -2048, -2048, -2048, "R8");

      // extremes
      step(1, 2047, 2047, 2047, 2047, "R7 all max");
      step(1, -2048, -2048, -2048, -2048, "R7 all min");
      step(1, 2047, -2048, 2047, -2048, "R7 alternate");
      step(1, -2048, 2047, -2048, 2047, "R7 alternate inv");
      step(1, -2048, 0, 0, 0, "R7 xa min");
      step(1, 0, 2047, -2048, 2047, "R7 int only");

      // random stream with occasional gaps
      for (int i = 0; i < 400; i++) begin
         if ($urandom % 5 == 0)
            step(0, rnd(), rnd(), rnd(), rnd(), "R8");
         else
            step(1, rnd(), rnd(), rnd(), rnd(), "R3/R4/R5/R6 random");
      end

      // drain the pipeline
      repeat (3) step(0, 0, 0, 0, 0, "R8");

      summary();
      $finish;
   end

endmodule